// File: doc/BRIEF.md
# Regulator Standby Wake Controller

This block decides whether an on-chip primary supply regulator runs or rests in low-power standby. Software controls it through one byte-wide register. The lowest bit is a power-down control. Writing a zero to it drops the regulator into standby on the next clock edge. Writing a one never turns the regulator on.

Once in standby, the regulator wakes only on external events. These are a rising edge on the ignition sense input, or a rising edge on the serial-bus line when the bus-wake strap is set. Both inputs pass through a two-flop synchronizer and an edge detector before they can wake the regulator.

The top bit of the register is read-only and shows the raw ignition pin level. A clamp-enable output follows standby when the clamp strap is set. A supply-valid input, active high, acts as the block's asynchronous reset. It stands in for the battery-level comparator.

Top module: `supply_standby_ctrl`

## Requirements
- R1: While supply_ok is low, reg_en is 0 and rd_data is 0x00. When supply_ok rises, the regulator starts in standby with the stored power-down bit at 0.
- R2: A write with wr_data bit 0 equal to 0 forces reg_en to 0 on the clock edge that captures the write. This holds whatever the levels of ign_in and bus_in.
- R3: A write with wr_data bit 0 equal to 1 never changes reg_en. An enabled regulator stays enabled and a standby regulator stays in standby.
- R4: rd_data bit 0 returns the power-down value last written. A wake does not set it to 1.
- R5: rd_data bit 7 equals the current ign_in level, combinationally and unfiltered, while supply_ok is high. rd_data bits 6 to 1 always read 0.
- R6: A rising edge on ign_in wakes the regulator. reg_en goes high after the third clock edge following the input change: two synchronizer stages plus the state register.
- R7: A rising edge on bus_in wakes the regulator with the same three-edge latency only when bus_wake_opt is 1. When bus_wake_opt is 0 the edge has no effect.
- R8: If a power-down write and a wake edge are captured on the same clock edge, the write wins and reg_en stays 0.
- R9: clamp_en is 1 exactly when clamp_opt is 1 and the regulator is in standby.
- R10: Only a synchronized low-to-high transition wakes the regulator. A falling edge or a steady level does not. The edge detectors clear to low on reset, so an input already high when supply_ok rises counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| supply_ok | input | 1 | Supply valid; low resets the block asynchronously |
| wr_en | input | 1 | One-cycle write strobe for the control register |
| wr_data | input | 8 | Write data; bit 0 is the power-down control |
| rd_data | output | 8 | Read data: bit 7 raw ignition level, bit 0 stored power-down bit |
| ign_in | input | 1 | Ignition sense input, asynchronous |
| bus_in | input | 1 | Serial-bus line, asynchronous |
| bus_wake_opt | input | 1 | Strap: bus activity may wake the regulator |
| clamp_opt | input | 1 | Strap: enable the supply clamp during standby |
| reg_en | output | 1 | Primary regulator enable |
| clamp_en | output | 1 | Supply clamp enable |

## Verification
Each result has its own due time.
- A write shows on reg_en, clamp_en and rd_data bit 0 one edge after it is captured.
- A change on ign_in reaches rd_data bit 7 at once.
- A wake edge on ign_in or bus_in shows on reg_en only after the third edge.

The bench's driver stamps every expected item with the cycle it is due in, counted from the cycle in which the stimulus was applied. The monitor compares each item in exactly that cycle, mid-cycle after the edge. Cycles before the due point are also checked, to show that a wake does not arrive early.

// File: rtl/sby_pkg.sv
package sby_pkg;
    localparam int REG_W       = 8;
    localparam int PD_BIT      = 0;
    localparam int IGN_BIT     = 7;
    localparam int SYNC_STAGES = 2;
    localparam int N_SRC       = 2;
    localparam int SRC_IGN     = 0;
    localparam int SRC_BUS     = 1;

    typedef struct packed {
        logic reg_on;
        logic pd;
    } mode_st_t;
endpackage

// File: rtl/sby_edge_sense.sv
module sby_edge_sense #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], din};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sync[STAGES-1] & ~st_q.prev;

    // R10: a detected edge lasts one cycle
    p_rise_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sby_mode_fsm.sv
module sby_mode_fsm
    import sby_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_pd,
    input  logic wake,
    output logic reg_on,
    output logic pd
);
    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.pd = wr_pd;
        if (wr_en && !wr_pd) st_d.reg_on = 1'b0;
        else if (wake)       st_d.reg_on = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_on = st_q.reg_on;
    assign pd     = st_q.pd;

    p_pd_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_pd) |=> !reg_on);

    p_one_keeps_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_on && wr_en && wr_pd) |=> reg_on);

    p_pd_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pd == $past(wr_pd)));

    p_wake_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_on) |-> $past(wake));

    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && wr_en && !wr_pd) |=> !reg_on);
endmodule

// File: rtl/supply_standby_ctrl.sv
module supply_standby_ctrl
    import sby_pkg::*;
(
    input  logic             clk,
    input  logic             supply_ok,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ign_in,
    input  logic             bus_in,
    input  logic             bus_wake_opt,
    input  logic             clamp_opt,
    output logic             reg_en,
    output logic             clamp_en
);
    logic [N_SRC-1:0] src_in;
    logic [N_SRC-1:0] src_rise;
    logic             wake;
    logic             pd;
    logic             wr_unused;

    assign src_in[SRC_IGN] = ign_in;
    assign src_in[SRC_BUS] = bus_in;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        sby_edge_sense #(.STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (supply_ok),
            .din   (src_in[g]),
            .rise  (src_rise[g])
        );
    end

    assign wake = src_rise[SRC_IGN] | (bus_wake_opt & src_rise[SRC_BUS]);

    sby_mode_fsm u_fsm (
        .clk    (clk),
        .rst_n  (supply_ok),
        .wr_en  (wr_en),
        .wr_pd  (wr_data[PD_BIT]),
        .wake   (wake),
        .reg_on (reg_en),
        .pd     (pd)
    );

    assign wr_unused = ^wr_data;

    always_comb begin
        rd_data          = '0;
        rd_data[PD_BIT]  = pd;
        rd_data[IGN_BIT] = ign_in & supply_ok;
    end

    assign clamp_en = clamp_opt & ~reg_en;

    p_clamp_excl_r9: assert property (@(posedge clk) disable iff (!supply_ok)
        reg_en |-> !clamp_en);

    p_bus_gated_r7: assert property (@(posedge clk) disable iff (!supply_ok)
        (!bus_wake_opt && !src_rise[SRC_IGN] && !reg_en) |=> !reg_en);
endmodule

// File: tb/tb_supply_standby_ctrl.sv
module tb_supply_standby_ctrl;
    logic       clk = 1'b0;
    logic       supply_ok = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ign_in = 1'b0;
    logic       bus_in = 1'b0;
    logic       bus_wake_opt = 1'b0;
    logic       clamp_opt = 1'b1;
    logic       reg_en;
    logic       clamp_en;

    always #10 clk = ~clk;

    supply_standby_ctrl dut (
        .clk(clk), .supply_ok(supply_ok), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ign_in(ign_in), .bus_in(bus_in),
        .bus_wake_opt(bus_wake_opt), .clamp_opt(clamp_opt),
        .reg_en(reg_en), .clamp_en(clamp_en)
    );

    typedef struct {
        int         due;
        logic [9:0] val;
        string      tag;
    } item_t;

    item_t q[$];
    int    cyc   = 0;
    int    tests = 0;
    int    fails = 0;

    task automatic cmp(string tag, logic [9:0] act, logic [9:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual reg=%b clamp=%b rd=%h expected reg=%b clamp=%b rd=%h",
                     tag, act[9], act[8], act[7:0], exp[9], exp[8], exp[7:0]);
        end
    endtask

    task automatic expect_at(int due, bit r, bit c, logic [7:0] rd, string tag);
        item_t it;
        it.due = due;
        it.val = {r, c, rd};
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(logic [7:0] d, bit r, bit c, logic [7:0] rd, string tag);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        expect_at(cyc + 1, r, c, rd, tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares items in their due cycle, mid-cycle
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #5;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due == cyc) begin
                    cmp(q[i].tag, {reg_en, clamp_en, rd_data}, q[i].val);
                    q.delete(i);
                end else if (q[i].due < cyc) begin
                    tests++;
                    fails++;
                    $display("FAIL %s: actual missed expected due cycle %0d", q[i].tag, q[i].due);
                    q.delete(i);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int c;
        idle(2);
        ign_in = 1'b1;
        #1 cmp("R1 held in reset, ign gated", {reg_en, clamp_en, rd_data}, {1'b0, 1'b1, 8'h00});
        ign_in = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        c = cyc;
        expect_at(c + 1, 0, 1, 8'h00, "R1 standby after supply valid");
        expect_at(c + 4, 0, 1, 8'h00, "R1 stays standby");
        idle(5);

        @(negedge clk);
        ign_in = 1'b1;
        c = cyc;
        expect_at(c + 1, 0, 1, 8'h80, "R5 ign bit mirrors pin");
        expect_at(c + 2, 0, 1, 8'h80, "R6 no wake before third edge");
        expect_at(c + 3, 1, 0, 8'h80, "R6 ign rise wakes, R9 clamp off");
        expect_at(c + 4, 1, 0, 8'h80, "R4 pd not set by wake");
        idle(6);

        wr(8'hFF, 1, 0, 8'h81, "R3 write one keeps on, R5 bits 6:1 zero");
        idle(3);
        wr(8'h7E, 0, 1, 8'h80, "R2 write zero enters standby");
        expect_at(cyc + 1, 0, 1, 8'h80, "R2 stays standby");
        wr(8'h01, 0, 1, 8'h81, "R3 write one in standby no wake");
        expect_at(cyc + 3, 0, 1, 8'h81, "R3 still standby");
        idle(5);

        @(negedge clk);
        ign_in = 1'b0;
        c = cyc;
        expect_at(c + 1, 0, 1, 8'h01, "R5 ign low mirrored");
        expect_at(c + 4, 0, 1, 8'h01, "R10 falling edge no wake");
        idle(6);

        @(negedge clk);
        bus_in = 1'b1;
        c = cyc;
        expect_at(c + 3, 0, 1, 8'h01, "R7 bus ignored with option off");
        expect_at(c + 5, 0, 1, 8'h01, "R7 bus still ignored");
        idle(6);
        bus_in = 1'b0;
        idle(4);
        bus_wake_opt = 1'b1;
        @(negedge clk);
        bus_in = 1'b1;
        c = cyc;
        expect_at(c + 2, 0, 1, 8'h01, "R7 bus wake not early");
        expect_at(c + 3, 1, 0, 8'h01, "R7 bus rise wakes with option on");
        idle(6);
        bus_in = 1'b0;

        wr(8'h00, 0, 1, 8'h00, "R2 standby before collision");
        idle(3);
        @(negedge clk);
        ign_in = 1'b1;
        c = cyc;
        expect_at(c + 1, 0, 1, 8'h80, "R5 ign high mirrored");
        @(negedge clk);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 8'h00;
        expect_at(c + 3, 0, 1, 8'h80, "R8 write wins over same-cycle wake");
        @(negedge clk);
        wr_en = 1'b0;
        expect_at(c + 5, 0, 1, 8'h80, "R8 no late wake");
        idle(4);

        @(negedge clk);
        bus_in = 1'b1;
        c = cyc;
        expect_at(c + 3, 1, 0, 8'h80, "R7 bus wake again");
        idle(5);
        wr(8'h00, 0, 1, 8'h80, "R2 write zero with ign and bus high");

        @(negedge clk);
        clamp_opt = 1'b0;
        c = cyc;
        expect_at(c + 1, 0, 0, 8'h80, "R9 clamp off with option off");
        idle(3);

        @(negedge clk);
        supply_ok = 1'b0;
        #1 cmp("R1 supply loss clears outputs", {reg_en, clamp_en, rd_data}, {1'b0, 1'b0, 8'h00});
        clamp_opt = 1'b1;
        ign_in    = 1'b0;
        bus_in    = 1'b0;
        idle(2);
        @(negedge clk);
        supply_ok = 1'b1;
        c = cyc;
        expect_at(c + 1, 0, 1, 8'h00, "R1 pd cleared after supply loss");
        idle(5);

        @(negedge clk);
        supply_ok = 1'b0;
        ign_in    = 1'b1;
        idle(2);
        @(negedge clk);
        supply_ok = 1'b1;
        c = cyc;
        expect_at(c + 1, 0, 1, 8'h80, "R10 standby right after supply valid");
        expect_at(c + 3, 1, 0, 8'h80, "R10 high level at supply valid counts as edge");
        idle(8);

        if (q.size() != 0) begin
            tests++;
            fails++;
            $display("FAIL scoreboard: actual %0d items left expected 0", q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule